// File: doc/BRIEF.md
# Windowed Read Stall Calculator

This block sits beside an instruction issue stage and works out how many extra cycles an instruction must stall when it reads operand data through the program-memory window. The issue stage presents one request per instruction: a 2-bit instruction class, a flag saying whether the instruction reads through the window, and the position of the instruction inside a hardware repeat loop. The block answers with a 2-bit extra-cycle count. It also drives a stall line that stays high for that many clocks, starting on the clock the request is accepted.

Outside a repeat loop the penalty depends only on the class. Inside a repeat loop it depends only on the position. The first and last iterations cost two cycles, and so do iterations disturbed by an interrupt, whether leaving the loop for it or returning after it. Steady iterations in the middle cost nothing.

Requests use a valid/ready handshake. A request is accepted on a clock where `req_valid` and `req_ready` are both high. `req_ready` falls while a countdown is still running. The issue stage must hold its request, or withdraw it, until `req_ready` returns. Any request presented while `req_ready` is low has no effect on the countdown. `extra_cycles` is a combinational decode of the present request fields.

Top module: `win_stall_calc`

## Requirements
- R1: When `win_access` is 0, `extra_cycles` is 0 whatever the other inputs are.
- R2: With `win_access`=1 and `in_loop`=0, class code 0 (multiply-accumulate with operand prefetch) gives `extra_cycles`=1.
- R3: With `win_access`=1 and `in_loop`=0, class codes 1 (plain move) and 2 (double move) give `extra_cycles`=1.
- R4: With `win_access`=1 and `in_loop`=0, class code 3 (any other instruction) gives `extra_cycles`=2.
- R5: With `win_access`=1 and `in_loop`=1, a first iteration (`first_iter`) or a last iteration (`last_iter`) gives `extra_cycles`=2 for every class.
- R6: With `win_access`=1 and `in_loop`=1, `irq_exit` or `irq_reentry` gives `extra_cycles`=2 for every class.
- R7: With `win_access`=1 and `in_loop`=1, if none of the four loop-position flags is set, `extra_cycles` is 0 for every class.
- R8: Several loop-position flags set together still give 2, never a sum. When `in_loop`=0 the four loop-position flags are ignored.
- R9: After an accepted request, `stall` is high for exactly `extra_cycles` consecutive clocks, beginning with the accepting clock. It stays low for a penalty of 0.
- R10: `req_ready` is low while a countdown is still running. A request held valid during that time is not accepted and does not lengthen or restart the stall.
- R11: Out of reset, `stall` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| instr_class | input | 2 | 0 MAC with prefetch, 1 move, 2 double move, 3 other |
| win_access | input | 1 | Instruction reads through the program window |
| in_loop | input | 1 | Instruction runs inside a repeat loop |
| first_iter | input | 1 | First loop iteration |
| last_iter | input | 1 | Last loop iteration |
| irq_exit | input | 1 | Iteration leaves the loop for an interrupt |
| irq_reentry | input | 1 | Iteration re-enters the loop after an interrupt |
| extra_cycles | output | 2 | Extra cycles for the present request |
| stall | output | 1 | Issue stall, high for the penalty length |

## Verification
The bench runs every class both outside and inside the loop. It sets each loop flag alone and in combinations, so a design that summed the loop penalties would show 3 or 4. The bench also sets loop flags with `in_loop` low. A design that did not ignore them there would give 2 where 1 is due. Stall length is measured per request and compared with the expected penalty. This catches a countdown that is off by one, and a stall that starts a clock late. One request is held valid while the block is busy. A design that accepted it would restart the countdown, and the measured stall would come out too long.

// File: rtl/win_stall_pkg.sv
package win_stall_pkg;
  localparam int PEN_W = 2;

  typedef enum logic [1:0] {
    CLS_MAC_PF   = 2'd0,
    CLS_MOVE     = 2'd1,
    CLS_MOVE_DBL = 2'd2,
    CLS_OTHER    = 2'd3
  } instr_cls_e;

  localparam logic [PEN_W-1:0] PEN_NONE  = 2'd0;
  localparam logic [PEN_W-1:0] PEN_SHORT = 2'd1;
  localparam logic [PEN_W-1:0] PEN_LONG  = 2'd2;
endpackage

// File: rtl/win_penalty_decode.sv
module win_penalty_decode
  import win_stall_pkg::*;
(
  input  logic [1:0]       cls_i,
  input  logic             win_i,
  input  logic             loop_i,
  input  logic [3:0]       edge_flags_i,
  output logic [PEN_W-1:0] pen_o
);
  instr_cls_e cls;
  logic       disturbed;

  assign cls       = instr_cls_e'(cls_i);
  assign disturbed = |edge_flags_i;

  always_comb begin
    pen_o = PEN_NONE;
    if (win_i) begin
      if (loop_i) begin
        pen_o = disturbed ? PEN_LONG : PEN_NONE;
      end else begin
        unique case (cls)
          CLS_MAC_PF, CLS_MOVE, CLS_MOVE_DBL: pen_o = PEN_SHORT;
          default:                            pen_o = PEN_LONG;
        endcase
      end
    end
  end
endmodule

// File: rtl/win_stall_counter.sv
module win_stall_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load_i) begin
      remain_q <= load_val_i;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign busy_o = (remain_q != '0);

  assert_count_monotone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && remain_q != '0) |=> (remain_q == $past(remain_q) - 1'b1));
endmodule

// File: rtl/win_stall_calc.sv
module win_stall_calc
  import win_stall_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       instr_class,
  input  logic             win_access,
  input  logic             in_loop,
  input  logic             first_iter,
  input  logic             last_iter,
  input  logic             irq_exit,
  input  logic             irq_reentry,
  output logic [PEN_W-1:0] extra_cycles,
  output logic             stall
);
  logic             accept;
  logic             busy;
  logic             nonzero;
  logic [PEN_W-1:0] load_val;

  win_penalty_decode u_decode (
    .cls_i        (instr_class),
    .win_i        (win_access),
    .loop_i       (in_loop),
    .edge_flags_i ({first_iter, last_iter, irq_exit, irq_reentry}),
    .pen_o        (extra_cycles)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign nonzero   = (extra_cycles != PEN_NONE);
  assign load_val  = nonzero ? extra_cycles - 1'b1 : '0;

  win_stall_counter #(.CNT_W(PEN_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept && nonzero),
    .load_val_i (load_val),
    .busy_o     (busy)
  );

  assign stall = busy || (accept && nonzero);

  assert_window_off_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !win_access |-> (extra_cycles == PEN_NONE));
  assert_steady_iter_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_access && in_loop && !(first_iter || last_iter || irq_exit || irq_reentry))
      |-> (extra_cycles == PEN_NONE));
  assert_never_summed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    extra_cycles != 2'd3);
  assert_long_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && extra_cycles == PEN_LONG) |=> (stall && !req_ready));
  assert_short_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && extra_cycles == PEN_SHORT) |=> req_ready);
  assert_zero_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && extra_cycles == PEN_NONE) |-> !stall);
  assert_busy_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> stall);
endmodule

// File: tb/win_stall_calc_tb_top.sv
module win_stall_calc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] instr_class = 2'd0;
  logic       win_access = 1'b0;
  logic       in_loop = 1'b0;
  logic       first_iter = 1'b0;
  logic       last_iter = 1'b0;
  logic       irq_exit = 1'b0;
  logic       irq_reentry = 1'b0;
  logic [1:0] extra_cycles;
  logic       stall;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_stall_calc dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .instr_class(instr_class), .win_access(win_access), .in_loop(in_loop),
    .first_iter(first_iter), .last_iter(last_iter), .irq_exit(irq_exit),
    .irq_reentry(irq_reentry), .extra_cycles(extra_cycles), .stall(stall)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: present one request, check decode, push expected stall length
  task automatic send(input string req, input logic [1:0] cls, input logic win,
                      input logic loop, input logic [3:0] flags, input int exp,
                      input bit hold_busy);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    instr_class = cls; win_access = win; in_loop = loop;
    {first_iter, last_iter, irq_exit, irq_reentry} = flags;
    req_valid = 1'b1;
    #1;
    check({req, " extra_cycles"}, int'(extra_cycles), exp);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    if (hold_busy) begin
      // R10: request stays valid while busy; must not be accepted
      instr_class = 2'd3; in_loop = 1'b0;
      check("R10 ready low while busy", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  // Monitor: measure stall length per accepted request
  initial begin : monitor
    bit tracking = 1'b0;
    int n = 0;
    int e = 0;
    string t = "";
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rst_n) begin
        if (tracking) begin
          if (stall && !(req_valid && req_ready)) n++;
          else begin
            check({t, " stall length"}, n, e);
            tracking = 1'b0;
          end
        end
        if (!tracking && req_valid && req_ready) begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          n = stall ? 1 : 0;
          if (stall) tracking = 1'b1;
          else check({t, " stall length"}, n, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 stall after reset", int'(stall), 0);
    check("R11 ready after reset", int'(req_ready), 1);
    rst_n = 1'b1;

    // R1: window off
    send("R1 off class3 loop", 2'd3, 1'b0, 1'b1, 4'b1111, 0, 1'b0);
    send("R1 off class0", 2'd0, 1'b0, 1'b0, 4'b0000, 0, 1'b0);
    // R2, R3, R4: outside loop
    send("R2 mac prefetch", 2'd0, 1'b1, 1'b0, 4'b0000, 1, 1'b0);
    send("R3 move", 2'd1, 1'b1, 1'b0, 4'b0000, 1, 1'b0);
    send("R3 double move", 2'd2, 1'b1, 1'b0, 4'b0000, 1, 1'b0);
    send("R4 other", 2'd3, 1'b1, 1'b0, 4'b0000, 2, 1'b0);
    // R8: loop flags ignored outside loop
    send("R8 flags ignored out of loop", 2'd1, 1'b1, 1'b0, 4'b1111, 1, 1'b0);
    // R5, R6: loop boundaries and interrupts
    send("R5 first iter", 2'd1, 1'b1, 1'b1, 4'b1000, 2, 1'b0);
    send("R5 last iter", 2'd0, 1'b1, 1'b1, 4'b0100, 2, 1'b0);
    send("R6 irq exit", 2'd2, 1'b1, 1'b1, 4'b0010, 2, 1'b0);
    send("R6 irq reentry", 2'd3, 1'b1, 1'b1, 4'b0001, 2, 1'b0);
    // R7: steady iterations, all classes
    for (int c = 0; c < 4; c++)
      send("R7 steady iter", 2'(c), 1'b1, 1'b1, 4'b0000, 0, 1'b0);
    // R8: combinations not summed
    send("R8 first+last", 2'd3, 1'b1, 1'b1, 4'b1100, 2, 1'b0);
    send("R8 all flags", 2'd0, 1'b1, 1'b1, 4'b1111, 2, 1'b0);
    // R9, R10: held request while busy, then back-to-back mix
    send("R10 hold while busy", 2'd3, 1'b1, 1'b0, 4'b0000, 2, 1'b1);
    send("R9 short after long", 2'd1, 1'b1, 1'b0, 4'b0000, 1, 1'b0);
    send("R9 long after short", 2'd3, 1'b1, 1'b1, 4'b0010, 2, 1'b0);

    repeat (6) @(negedge clk);
    check("R9 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule